// File: doc/BRIEF.md
# Transport Stream Capture Event and Interrupt Controller

This block tracks how far a transport stream capture engine has filled its current buffer. Each time a 188-byte packet starts, the block either accepts it, which moves the write position forward by one packet slot, or drops it because the buffer already holds its full capacity. When an accepted packet brings the count up to a programmed threshold, the block records an end-of-transfer event. When a packet is dropped, it records an overflow event. Both events are sticky. An interrupt line is raised while an event is pending and its source is not masked.

Software controls the block through a single 32-bit control/status word and a buffer base-address register. The word holds:
- an active-low run bit that holds the stream logic in reset while it is low;
- four per-source masks;
- the two sticky event flags;
- a write-one acknowledge bit;
- the live packet count;
- an almost-full indication;
- the lock input from the frontend;
- the packet threshold.

Writing the base-address register points the write position back at the start of the buffer and clears the count, ready for the next transfer.

Top module: `ts_dma_irq_ctrl`

## Requirements
- R1: After reset the status word reads 0x00027004 (with `lock_in` low): masks at bits 17, 14, 13 and 12 set, run bit 15 clear, threshold in bits 6:0 equal to half the buffer capacity (4 for 8 packets), count and flags zero; `irq` is low and `wr_addr` is 0.
- R2: While bit 15 is 1, each `pkt_start` seen with fewer than BUF_PKTS packets in the buffer is accepted (`pkt_accept` high in that cycle). From the next cycle, the count in bits 31:24 is one higher and `wr_addr` equals base + count * 188.
- R3: An accepted packet that makes the count equal a nonzero threshold (bits 6:0) sets the end-of-transfer flag at bit 16. A threshold of 0 never sets it.
- R4: A `pkt_start` while bit 15 is 1 and the count equals BUF_PKTS drives `pkt_drop` high and `pkt_accept` low in that cycle, sets the overflow flag at bit 11, and leaves the count unchanged.
- R5: Flags at bits 16 and 11 stay set until a status-word write with bit 8 = 1, which clears both. A write with bit 8 = 0 leaves them unchanged. An event in the same cycle as an acknowledge stays set. Bit 8 always reads 0.
- R6: `irq` is high exactly when (bit 16 and not bit 17) or (bit 11 and not bit 14). Almost-full, lock and their masks (bits 13, 12) never raise it.
- R7: While bit 15 is 0, the count is cleared within one cycle and held at 0, and `pkt_start` is ignored: no count, no flag, no drop. Setting bit 15 again resumes counting from 0.
- R8: Writing the base-address register loads the new base and clears the count. A packet accepted in the same cycle is the first packet of the new buffer (count 1).
- R9: Bit 10 reads 1 when the count is at least BUF_PKTS - AF_MARGIN (6 by default). Bit 9 follows `lock_in`.
- R10: Status-word writes store only bits 17, 15, 14, 13, 12 and 6:0. Writes to bits 31:24, 16, 11, 10 and 9 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Write strobe for the control/status word |
| csr_wdata | input | 32 | Control/status write data |
| addr_wr | input | 1 | Write strobe for the buffer base address |
| addr_wdata | input | ADDR_W | New buffer base address |
| pkt_start | input | 1 | One-cycle pulse: a packet begins |
| lock_in | input | 1 | Frontend lock status |
| csr_rdata | output | 32 | Current control/status word |
| wr_addr | output | ADDR_W | Write position for the next packet |
| pkt_accept | output | 1 | The packet starting this cycle is stored |
| pkt_drop | output | 1 | The packet starting this cycle is dropped |
| irq | output | 1 | Interrupt request |

## Verification
Count, flags, base address and control fields are registered. They show their new values one clock edge after the write or packet pulse that changes them. `irq`, bit 9 and the accept/drop strobes are combinational and follow their inputs in the same cycle. Clearing the run bit takes two edges to empty the count: one edge to store the bit and one to clear the count. The bench therefore drives every stimulus on a falling edge and checks registered results at the next falling edge. It samples the accept/drop strobes while the pulse is still applied, and waits one extra cycle after a run-bit clear.

// File: rtl/ts_dma_pkg.sv
package ts_dma_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned THR_W      = 7;
    localparam int unsigned CNT_FLD_W  = 8;

    // bit positions inside the control/status word
    localparam int unsigned POS_CNT    = 24;
    localparam int unsigned POS_DE_MSK = 17;
    localparam int unsigned POS_DE     = 16;
    localparam int unsigned POS_RUN_N  = 15;
    localparam int unsigned POS_OV_MSK = 14;
    localparam int unsigned POS_AF_MSK = 13;
    localparam int unsigned POS_LK_MSK = 12;
    localparam int unsigned POS_OV     = 11;
    localparam int unsigned POS_AF     = 10;
    localparam int unsigned POS_LK     = 9;
    localparam int unsigned POS_ACK    = 8;

    typedef struct packed {
        logic             de_msk;
        logic             ov_msk;
        logic             af_msk;
        logic             lk_msk;
        logic             run_n;
        logic [THR_W-1:0] thr;
    } ctrl_t;

    typedef struct packed {
        logic de;
        logic ov;
    } evt_t;

    function automatic ctrl_t ctrl_from_word(input logic [WORD_W-1:0] w);
        ctrl_t c;
        c.de_msk = w[POS_DE_MSK];
        c.ov_msk = w[POS_OV_MSK];
        c.af_msk = w[POS_AF_MSK];
        c.lk_msk = w[POS_LK_MSK];
        c.run_n  = w[POS_RUN_N];
        c.thr    = w[THR_W-1:0];
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] status_word(
        input ctrl_t                c,
        input evt_t                 e,
        input logic                 af,
        input logic                 lk,
        input logic [CNT_FLD_W-1:0] cnt
    );
        logic [WORD_W-1:0] w;
        w = '0;
        w[POS_CNT +: CNT_FLD_W] = cnt;
        w[POS_DE_MSK]           = c.de_msk;
        w[POS_DE]               = e.de;
        w[POS_RUN_N]            = c.run_n;
        w[POS_OV_MSK]           = c.ov_msk;
        w[POS_AF_MSK]           = c.af_msk;
        w[POS_LK_MSK]           = c.lk_msk;
        w[POS_OV]               = e.ov;
        w[POS_AF]               = af;
        w[POS_LK]               = lk;
        w[THR_W-1:0]            = c.thr;
        return w;
    endfunction

endpackage

// File: rtl/tsd_ctrl_reg.sv
module tsd_ctrl_reg
    import ts_dma_pkg::*;
#(
    parameter int unsigned THR_RST = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [WORD_W-1:0] wdata,
    output ctrl_t             ctrl
);
    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.de_msk <= 1'b1;
            ctrl_q.ov_msk <= 1'b1;
            ctrl_q.af_msk <= 1'b1;
            ctrl_q.lk_msk <= 1'b1;
            ctrl_q.run_n  <= 1'b0;
            ctrl_q.thr    <= THR_W'(THR_RST);
        end else if (wr) begin
            ctrl_q <= ctrl_from_word(wdata);
        end
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/tsd_pkt_counter.sv
module tsd_pkt_counter
    import ts_dma_pkg::*;
#(
    parameter int unsigned BUF_PKTS  = 8,
    parameter int unsigned PKT_BYTES = 188,
    parameter int unsigned AF_MARGIN = 2,
    parameter int unsigned ADDR_W    = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run_n,
    input  logic [THR_W-1:0]     thr,
    input  logic                 addr_wr,
    input  logic [ADDR_W-1:0]    addr_wdata,
    input  logic                 pkt_start,
    output logic [CNT_FLD_W-1:0] cnt,
    output logic [ADDR_W-1:0]    wr_addr,
    output logic                 accept,
    output logic                 drop,
    output logic                 thr_hit,
    output logic                 almost_full
);
    localparam int unsigned CNT_W    = $clog2(BUF_PKTS + 1);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(BUF_PKTS);
    localparam logic [CNT_W-1:0] AF_LVL = CNT_W'(BUF_PKTS - AF_MARGIN);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PKT_BYTES);

    logic [CNT_W-1:0]  cnt_q, cnt_eff, cnt_inc, cnt_d;
    logic [ADDR_W-1:0] base_q;
    logic              active, full;

    // an address write restarts the buffer before the packet of this cycle lands
    assign cnt_eff = addr_wr ? '0 : cnt_q;
    assign cnt_inc = cnt_eff + 1'b1;
    assign active  = pkt_start & run_n;
    assign full    = (cnt_eff == CAP);
    assign accept  = active & ~full;
    assign drop    = active & full;
    assign thr_hit = accept && (thr != '0)
                     && (CNT_FLD_W'(cnt_inc) == CNT_FLD_W'(thr));

    always_comb begin
        if (!run_n)      cnt_d = '0;
        else if (accept) cnt_d = cnt_inc;
        else             cnt_d = cnt_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            base_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (addr_wr) base_q <= addr_wdata;
        end
    end

    generate
        if (AF_MARGIN == 0) begin : g_af_full
            assign almost_full = (cnt_q == CAP);
        end else begin : g_af_margin
            assign almost_full = (cnt_q >= AF_LVL);
        end
    endgenerate

    assign cnt     = CNT_FLD_W'(cnt_q);
    assign wr_addr = base_q + ADDR_W'(cnt_q) * STEP;
endmodule

// File: rtl/tsd_event_flags.sv
module tsd_event_flags
    import ts_dma_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_de,
    input  logic set_ov,
    input  logic ack,
    input  logic de_msk,
    input  logic ov_msk,
    output evt_t flags,
    output logic irq
);
    evt_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else begin
            // new events win over an acknowledge in the same cycle
            flags_q.de <= set_de | (flags_q.de & ~ack);
            flags_q.ov <= set_ov | (flags_q.ov & ~ack);
        end
    end

    assign flags = flags_q;
    assign irq   = (flags_q.de & ~de_msk) | (flags_q.ov & ~ov_msk);
endmodule

// File: rtl/ts_dma_irq_ctrl.sv
module ts_dma_irq_ctrl
    import ts_dma_pkg::*;
#(
    parameter int unsigned BUF_PKTS  = 8,
    parameter int unsigned PKT_BYTES = 188,
    parameter int unsigned AF_MARGIN = 2,
    parameter int unsigned ADDR_W    = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              csr_wr,
    input  logic [31:0]       csr_wdata,
    input  logic              addr_wr,
    input  logic [ADDR_W-1:0] addr_wdata,
    input  logic              pkt_start,
    input  logic              lock_in,
    output logic [31:0]       csr_rdata,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              pkt_accept,
    output logic              pkt_drop,
    output logic              irq
);
    localparam int unsigned THR_RST = BUF_PKTS / 2;

    ctrl_t                ctrl;
    evt_t                 flags;
    logic [CNT_FLD_W-1:0] cnt;
    logic                 thr_hit, almost_full, ack;

    assign ack = csr_wr & csr_wdata[POS_ACK];

    tsd_ctrl_reg #(.THR_RST(THR_RST)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .wr    (csr_wr),
        .wdata (csr_wdata),
        .ctrl  (ctrl)
    );

    tsd_pkt_counter #(
        .BUF_PKTS  (BUF_PKTS),
        .PKT_BYTES (PKT_BYTES),
        .AF_MARGIN (AF_MARGIN),
        .ADDR_W    (ADDR_W)
    ) u_cnt (
        .clk         (clk),
        .rst         (rst),
        .run_n       (ctrl.run_n),
        .thr         (ctrl.thr),
        .addr_wr     (addr_wr),
        .addr_wdata  (addr_wdata),
        .pkt_start   (pkt_start),
        .cnt         (cnt),
        .wr_addr     (wr_addr),
        .accept      (pkt_accept),
        .drop        (pkt_drop),
        .thr_hit     (thr_hit),
        .almost_full (almost_full)
    );

    tsd_event_flags u_evt (
        .clk    (clk),
        .rst    (rst),
        .set_de (thr_hit),
        .set_ov (pkt_drop),
        .ack    (ack),
        .de_msk (ctrl.de_msk),
        .ov_msk (ctrl.ov_msk),
        .flags  (flags),
        .irq    (irq)
    );

    assign csr_rdata = status_word(ctrl, flags, almost_full, lock_in, cnt);
endmodule

// File: rtl/ts_dma_irq_chk.sv
module ts_dma_irq_chk #(
    parameter int unsigned BUF_PKTS = 8,
    parameter int unsigned ADDR_W   = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              csr_wr,
    input logic [31:0]       csr_wdata,
    input logic              addr_wr,
    input logic [ADDR_W-1:0] addr_wdata,
    input logic              pkt_start,
    input logic [31:0]       csr_rdata,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              pkt_drop,
    input logic              irq
);
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        csr_rdata[31:24] <= 8'(BUF_PKTS)); // R2

    AST_OVF_DROP: assert property (@(posedge clk) disable iff (rst)
        (pkt_start && csr_rdata[15] && !addr_wr && csr_rdata[31:24] == 8'(BUF_PKTS))
        |=> (csr_rdata[11] && csr_rdata[31:24] == $past(csr_rdata[31:24]))); // R4

    AST_DROP_ONLY_FULL: assert property (@(posedge clk) disable iff (rst)
        pkt_drop |-> (csr_rdata[31:24] == 8'(BUF_PKTS) && !addr_wr)); // R4

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (csr_wr && csr_wdata[8] && !pkt_start) |=> (!csr_rdata[16] && !csr_rdata[11])); // R5

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (csr_rdata[16] && !(csr_wr && csr_wdata[8])) |=> csr_rdata[16]); // R5

    AST_IRQ_SOURCES: assert property (@(posedge clk) disable iff (rst)
        irq == ((csr_rdata[16] && !csr_rdata[17]) || (csr_rdata[11] && !csr_rdata[14]))); // R6

    AST_HELD_IN_RESET: assert property (@(posedge clk) disable iff (rst)
        !csr_rdata[15] |=> (csr_rdata[31:24] == 8'd0)); // R7

    AST_ADDR_RESTART: assert property (@(posedge clk) disable iff (rst)
        (addr_wr && !pkt_start) |=> (wr_addr == $past(addr_wdata) && csr_rdata[31:24] == 8'd0)); // R8
endmodule

bind ts_dma_irq_ctrl ts_dma_irq_chk #(.BUF_PKTS(BUF_PKTS), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .csr_wr     (csr_wr),
    .csr_wdata  (csr_wdata),
    .addr_wr    (addr_wr),
    .addr_wdata (addr_wdata),
    .pkt_start  (pkt_start),
    .csr_rdata  (csr_rdata),
    .wr_addr    (wr_addr),
    .pkt_drop   (pkt_drop),
    .irq        (irq)
);

// File: tb/sim_ts_dma_irq_ctrl.sv
module sim_ts_dma_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        csr_wr = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic        addr_wr = 1'b0;
    logic [31:0] addr_wdata = '0;
    logic        pkt_start = 1'b0;
    logic        lock_in = 1'b0;
    logic [31:0] csr_rdata, wr_addr;
    logic        pkt_accept, pkt_drop, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ts_dma_irq_ctrl u0 (
        .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .addr_wr(addr_wr), .addr_wdata(addr_wdata), .pkt_start(pkt_start),
        .lock_in(lock_in), .csr_rdata(csr_rdata), .wr_addr(wr_addr),
        .pkt_accept(pkt_accept), .pkt_drop(pkt_drop), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic csr_write(input logic [31:0] w);
        csr_wr = 1'b1; csr_wdata = w;
        tick;
        csr_wr = 1'b0; csr_wdata = '0;
    endtask

    task automatic addr_write(input logic [31:0] a);
        addr_wr = 1'b1; addr_wdata = a;
        tick;
        addr_wr = 1'b0;
    endtask

    task automatic pkts(input int n);
        for (int i = 0; i < n; i++) begin
            pkt_start = 1'b1;
            tick;
            pkt_start = 1'b0;
        end
    endtask

    task automatic t_reset;
        chk("R1 status word", csr_rdata, 32'h0002_7004);
        chk("R1 irq", {31'b0, irq}, 32'd0);
        chk("R1 wr_addr", wr_addr, 32'd0);
    endtask

    task automatic t_setup;
        addr_write(32'h0000_1000);
        csr_write(32'h0000_B104);           // run, unmask DE/OV, thr 4, ack
        chk("R10 stored fields", csr_rdata, 32'h0000_B004);
        chk("R8 base loaded", wr_addr, 32'h0000_1000);
    endtask

    task automatic t_count_and_done;
        pkts(3);
        chk("R2 count 3", csr_rdata, 32'h0300_B004);
        chk("R2 wr_addr", wr_addr, 32'h0000_1000 + 3 * 188);
        pkt_start = 1'b1; #1;
        chk("R2 accept strobe", {30'b0, pkt_accept, pkt_drop}, 32'd2);
        tick; pkt_start = 1'b0;
        chk("R3 done flag at threshold", csr_rdata, 32'h0401_B004);
        chk("R6 irq from done", {31'b0, irq}, 32'd1);
    endtask

    task automatic t_sticky;
        csr_write(32'h0000_B004);
        chk("R5 no-ack write keeps flag", csr_rdata, 32'h0401_B004);
        csr_write(32'h0002_B004);
        chk("R6 masked done no irq", {31'b0, irq}, 32'd0);
        chk("R5 flag kept under mask", {31'b0, csr_rdata[16]}, 32'd1);
        csr_write(32'h0000_B104);
        chk("R5 ack clears", csr_rdata, 32'h0400_B004);
        chk("R6 irq low after ack", {31'b0, irq}, 32'd0);
    endtask

    task automatic t_status_bits;
        pkts(1);
        chk("R9 not almost full at 5", {31'b0, csr_rdata[10]}, 32'd0);
        pkts(1);
        chk("R9 almost full at 6", {31'b0, csr_rdata[10]}, 32'd1);
        lock_in = 1'b1; #1;
        chk("R9 lock follows input", {31'b0, csr_rdata[9]}, 32'd1);
        csr_write(32'h0000_8004);           // unmask almost-full and lock sources
        chk("R6 af/lock never irq", {31'b0, irq}, 32'd0);
        lock_in = 1'b0;
        csr_write(32'h0000_B004);
    endtask

    task automatic t_overflow;
        pkts(2);
        chk("R2 full buffer", csr_rdata, 32'h0800_B404);
        pkt_start = 1'b1; #1;
        chk("R4 drop strobe", {30'b0, pkt_accept, pkt_drop}, 32'd1);
        tick; pkt_start = 1'b0;
        chk("R4 overflow flag, count held", csr_rdata, 32'h0800_BC04);
        chk("R4 wr_addr held", wr_addr, 32'h0000_1000 + 8 * 188);
        chk("R6 irq from overflow", {31'b0, irq}, 32'd1);
        csr_write(32'h0000_B104);
        // ack and a fresh overflow in the same cycle: event wins
        pkt_start = 1'b1; csr_wr = 1'b1; csr_wdata = 32'h0000_B104;
        tick;
        pkt_start = 1'b0; csr_wr = 1'b0; csr_wdata = '0;
        chk("R5 event beats ack", {31'b0, csr_rdata[11]}, 32'd1);
        csr_write(32'h0000_B104);
        chk("R5 ack clears overflow", {31'b0, csr_rdata[11]}, 32'd0);
    endtask

    task automatic t_restart;
        addr_write(32'h0000_2000);
        chk("R8 count cleared", csr_rdata[31:24], 32'd0);
        chk("R8 wr_addr at new base", wr_addr, 32'h0000_2000);
        addr_wr = 1'b1; addr_wdata = 32'h0000_3000; pkt_start = 1'b1;
        tick;
        addr_wr = 1'b0; pkt_start = 1'b0;
        chk("R8 same-cycle packet counted", csr_rdata[31:24], 32'd1);
        chk("R8 wr_addr after first packet", wr_addr, 32'h0000_3000 + 188);
    endtask

    task automatic t_soft_reset;
        csr_write(32'h0000_3004);
        tick;
        chk("R7 count cleared in reset", csr_rdata, 32'h0000_3004);
        pkts(4);
        chk("R7 packets ignored", csr_rdata, 32'h0000_3004);
        pkt_start = 1'b1; #1;
        chk("R7 no strobes", {30'b0, pkt_accept, pkt_drop}, 32'd0);
        tick; pkt_start = 1'b0;
        csr_write(32'h0000_B004);
        pkts(1);
        chk("R7 resumes from zero", csr_rdata[31:24], 32'd1);
    endtask

    task automatic t_thresholds;
        addr_write(32'h0000_4000);
        csr_write(32'h0000_B001);
        pkts(1);
        chk("R3 threshold 1", {31'b0, csr_rdata[16]}, 32'd1);
        csr_write(32'h0000_B100);           // threshold 0, ack
        addr_write(32'h0000_5000);
        pkts(8);
        chk("R3 threshold 0 never done", {31'b0, csr_rdata[16]}, 32'd0);
        csr_write(32'hFF01_BE04);
        chk("R10 read-only bits unaffected", csr_rdata, 32'h0800_B404);
    endtask

    initial begin
        repeat (3) tick;
        rst = 1'b0;
        tick;
        t_reset;
        t_setup;
        t_count_and_done;
        t_sticky;
        t_status_bits;
        t_overflow;
        t_restart;
        t_soft_reset;
        t_thresholds;
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule